// File: doc/BRIEF.md
# Register Init Table Sequencer

This block walks a command table stored in a byte-wide ROM and replays it onto a 32-bit register bus. A start pulse supplies the table's byte address. The sequencer then fetches one 16-bit header word at a time and decodes a 3-bit opcode and a 13-bit register index from it. It fetches whatever little-endian operand bytes that opcode needs and carries out the command. A command is a direct or indexed register write, a masked read-modify-write, a delay counted in microseconds, or a bounded poll of a memory-controller status condition. When it meets a zero header, the walk ends and `done` pulses.

Indexed access goes through a pair of registers. The index is first written to an index register, and the value then moves through a data register. Polls read a clock power-management register or a memory status register once per cycle, up to a count taken from the table. A poll that runs out of attempts sets a sticky timeout flag and the walk goes on. An undefined opcode ends the walk and sets a sticky error flag.

Top module: `reg_init_seq`

## Requirements
- R1: A start pulse with a table address of zero makes `done` high in the next cycle, and no bus access occurs.
- R2: Each header is read little-endian from ROM at the current address and the address plus one. Bits 15:13 hold the opcode and bits 12:0 hold the index. Every operand is little-endian and follows its header directly. A header equal to zero ends the walk with a one-cycle `done` pulse.
- R3: Opcode 000 first writes the index, zero-extended, to the index register (parameter `IDX_REG_ADDR`). It then writes the 4-byte operand to the data register (parameter `DATA_REG_ADDR`).
- R4: Opcode 001 writes the 4-byte operand to the register addressed by the index.
- R5: Opcode 010 fetches a 4-byte AND mask followed by a 4-byte OR mask. It writes the index to the index register, reads the data register, and writes back (read AND andmask) OR ormask.
- R6: Opcode 011 fetches the same two masks and performs the same read-modify-write directly on the register addressed by the index.
- R7: Opcode 100 fetches a 2-byte count N and adds exactly N × `CYC_PER_US` cycles to the walk. N = 0 adds no cycles.
- R8: Opcode 101 fetches a 2-byte count, and its sub-command sits in header bits 7:0. Sub-command 0x03 reads `CLKPM_ADDR` once per cycle until bit `BUSY_BIT` reads 0, making at most count reads.
- R9: Sub-command 0x08 reads `MEM_STAT_ADDR` until every power-up bit is set. The mask is 0x03 when `CHANNELS` = 2 and 0x0F when `CHANNELS` = 4. The read limit is the same as in R8.
- R10: A poll whose count is used up without success, including a count of 0, sets `timeout`. The walk continues with the next entry. `timeout` stays set until the next accepted start.
- R11: Opcode 110 or 111 ends the walk with a `done` pulse and sets `error`. Later entries are not executed. `error` stays set until the next accepted start.
- R12: Opcode 101 with a sub-command other than 0x03 or 0x08 consumes its 2-byte count and makes no bus access.
- R13: A start that arrives while a walk is running is ignored. `done` is never high in two consecutive cycles. Bus read and write never occur together, and neither occurs while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| tableAddr | input | ADDR_W | ROM byte address of the table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| timeout | output | 1 | Sticky: a poll ran out of attempts |
| error | output | 1 | Sticky: undefined opcode met |
| romAddr | output | ADDR_W | ROM byte address |
| romData | input | 8 | ROM byte, combinational from romAddr |
| regAddr | output | IDX_W | Register bus address |
| regWrite | output | 1 | Register write strobe |
| regRead | output | 1 | Register read strobe |
| regWdata | output | DATA_W | Register write data |
| regRdata | input | DATA_W | Register read data, valid in the read cycle |

## Verification
Two things can land in the same cycle. The first is a poll attempt that succeeds on its last permitted read. That read must count as a success, and the timeout flag must stay clear. The bench provokes this by sweeping how many busy reads the status model returns against the poll count, so that the busy-to-clear change falls before, on and after the final attempt. For every pair it judges the number of status reads and the timeout flag against min(K+1, count) and K ≥ count. The second case is a start pulse that arrives in the middle of a running delay. The bench checks that this start starts no second walk and leaves the registers of the second table untouched.

// File: rtl/reg_init_seq_pkg.sv
package reg_init_seq_pkg;

  localparam logic [2:0] OP_WR_IDX  = 3'b000;
  localparam logic [2:0] OP_WR_DIR  = 3'b001;
  localparam logic [2:0] OP_RMW_IDX = 3'b010;
  localparam logic [2:0] OP_RMW_DIR = 3'b011;
  localparam logic [2:0] OP_DELAY   = 3'b100;
  localparam logic [2:0] OP_SPECIAL = 3'b101;

  localparam logic [7:0] SUB_MC_IDLE  = 8'h03;
  localparam logic [7:0] SUB_MEM_PWUP = 8'h08;

  typedef enum logic [1:0] {
    ASEL_HDR, ASEL_IDXREG, ASEL_DATAREG, ASEL_POLL
  } addrSel_e;

  typedef enum logic [1:0] {
    WSEL_INDEX, WSEL_OPA, WSEL_RMW
  } wdSel_e;

  typedef struct packed {
    logic     loadPtr;
    logic     incPtr;
    logic     ldHdrLo;
    logic     ldHdrHi;
    logic     ldOp;
    logic     clrByte;
    logic     ldCount;
    logic     tick;
    logic     decCount;
    logic     ldRd;
    logic     busWr;
    logic     busRd;
    addrSel_e aSel;
    wdSel_e   wSel;
  } strobe_t;

endpackage

// File: rtl/reg_init_seq_dpath.sv
module reg_init_seq_dpath
  import reg_init_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W = 13,
  parameter int DATA_W = 32,
  parameter int CYC_PER_US = 100,
  parameter int CHANNELS = 2,
  parameter int BUSY_BIT = 16,
  parameter logic [IDX_W-1:0] IDX_REG_ADDR = 13'h0000,
  parameter logic [IDX_W-1:0] DATA_REG_ADDR = 13'h0004,
  parameter logic [IDX_W-1:0] CLKPM_ADDR = 13'h0012,
  parameter logic [IDX_W-1:0] MEM_STAT_ADDR = 13'h0150
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [ADDR_W-1:0] tableAddr,
  input  logic [7:0]        romData,
  input  logic [DATA_W-1:0] regRdata,
  output logic [ADDR_W-1:0] romAddr,
  output logic [IDX_W-1:0]  regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWrite,
  output logic              regRead,
  output logic [15:0]       hdr,
  output logic [2:0]        byteIdx,
  output logic              countZero,
  output logic              remLast,
  output logic              delayLast,
  output logic              pollOk
);

  localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CYC_PER_US - 1);
  localparam int OPND_W = 2 * DATA_W;

  logic [ADDR_W-1:0] ptr;
  logic [OPND_W-1:0] opnd;
  logic [DATA_W-1:0] rdHold;
  logic [15:0]       rem;
  logic [PRE_W-1:0]  pre;
  logic              memReady;
  logic [DATA_W-1:0] opA, opB;

  assign opA = opnd[DATA_W-1:0];
  assign opB = opnd[OPND_W-1:DATA_W];
  assign romAddr = ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      hdr     <= '0;
      opnd    <= '0;
      byteIdx <= '0;
      rdHold  <= '0;
    end else begin
      if (st.loadPtr)     ptr <= tableAddr;
      else if (st.incPtr) ptr <= ptr + 1'b1;
      if (st.ldHdrLo) hdr[7:0]  <= romData;
      if (st.ldHdrHi) hdr[15:8] <= romData;
      if (st.clrByte) byteIdx <= '0;
      else if (st.ldOp) begin
        opnd[{byteIdx, 3'b000} +: 8] <= romData;
        byteIdx <= byteIdx + 1'b1;
      end
      if (st.ldRd) rdHold <= regRdata;
    end
  end

  // shared counter: microsecond delay or remaining poll attempts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem <= '0;
      pre <= '0;
    end else if (st.ldCount) begin
      rem <= opnd[15:0];
      pre <= PRE_MAX;
    end else if (st.tick) begin
      if (pre == '0) begin
        pre <= PRE_MAX;
        rem <= rem - 1'b1;
      end else begin
        pre <= pre - 1'b1;
      end
    end else if (st.decCount) begin
      rem <= rem - 1'b1;
    end
  end

  assign countZero = (opnd[15:0] == 16'd0);
  assign remLast   = (rem == 16'd1);
  assign delayLast = (rem == 16'd1) && (pre == '0);

  generate
    if (CHANNELS == 4) begin : g_four
      assign memReady = &regRdata[3:0];
    end else begin : g_two
      assign memReady = &regRdata[1:0];
    end
  endgenerate

  assign pollOk = (hdr[7:0] == SUB_MC_IDLE) ? !regRdata[BUSY_BIT] : memReady;

  always_comb begin
    case (st.aSel)
      ASEL_IDXREG:  regAddr = IDX_REG_ADDR;
      ASEL_DATAREG: regAddr = DATA_REG_ADDR;
      ASEL_POLL:    regAddr = (hdr[7:0] == SUB_MC_IDLE) ? CLKPM_ADDR : MEM_STAT_ADDR;
      default:      regAddr = hdr[IDX_W-1:0];
    endcase
    case (st.wSel)
      WSEL_INDEX: regWdata = DATA_W'(hdr[IDX_W-1:0]);
      WSEL_RMW:   regWdata = (rdHold & opA) | opB;
      default:    regWdata = opA;
    endcase
  end

  assign regWrite = st.busWr;
  assign regRead  = st.busRd;

  // R7: between prescaler wraps the remaining microsecond count holds
  assert_delay_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st.tick && !st.ldCount && pre != '0) |=> (rem == $past(rem)));

  // R8: a poll attempt is never spent when none remain
  assert_poll_budget_R8: assert property (@(posedge clk) disable iff (!rstN)
    st.decCount |-> (rem != 16'd0));

endmodule

// File: rtl/reg_init_seq_ctrl.sv
module reg_init_seq_ctrl
  import reg_init_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] tableAddr,
  input  logic [15:0]       hdr,
  input  logic [2:0]        byteIdx,
  input  logic              countZero,
  input  logic              remLast,
  input  logic              delayLast,
  input  logic              pollOk,
  output strobe_t           st,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              error
);

  typedef enum logic [3:0] {
    S_IDLE, S_HDR0, S_HDR1, S_DECODE, S_OPND, S_DISPATCH,
    S_WIDX, S_WDAT, S_RDV, S_WBK, S_DELAY, S_POLL, S_FIN
  } state_e;

  state_e state, nextState;
  logic setTo, setErr;
  logic [2:0] opc;
  logic [2:0] lastByte;
  logic accept;

  assign opc    = hdr[15:13];
  assign accept = (state == S_IDLE) && start;

  always_comb begin
    case (opc)
      OP_WR_IDX, OP_WR_DIR:   lastByte = 3'd3;
      OP_RMW_IDX, OP_RMW_DIR: lastByte = 3'd7;
      default:                lastByte = 3'd1;
    endcase
  end

  always_comb begin
    st        = '0;
    nextState = state;
    setTo     = 1'b0;
    setErr    = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          if (tableAddr == '0) nextState = S_FIN;
          else begin
            st.loadPtr = 1'b1;
            nextState  = S_HDR0;
          end
        end
      end
      S_HDR0: begin
        st.ldHdrLo = 1'b1;
        st.incPtr  = 1'b1;
        nextState  = S_HDR1;
      end
      S_HDR1: begin
        st.ldHdrHi = 1'b1;
        st.incPtr  = 1'b1;
        st.clrByte = 1'b1;
        nextState  = S_DECODE;
      end
      S_DECODE: begin
        if (hdr == 16'd0) nextState = S_FIN;
        else if (opc[2:1] == 2'b11) begin
          setErr    = 1'b1;
          nextState = S_FIN;
        end else nextState = S_OPND;
      end
      S_OPND: begin
        st.ldOp   = 1'b1;
        st.incPtr = 1'b1;
        if (byteIdx == lastByte) nextState = S_DISPATCH;
      end
      S_DISPATCH: begin
        st.ldCount = 1'b1;
        case (opc)
          OP_WR_IDX, OP_RMW_IDX: nextState = S_WIDX;
          OP_WR_DIR:             nextState = S_WDAT;
          OP_RMW_DIR:            nextState = S_RDV;
          OP_DELAY:              nextState = countZero ? S_HDR0 : S_DELAY;
          default: begin
            if (hdr[7:0] == SUB_MC_IDLE || hdr[7:0] == SUB_MEM_PWUP) begin
              if (countZero) begin
                setTo     = 1'b1;
                nextState = S_HDR0;
              end else nextState = S_POLL;
            end else nextState = S_HDR0;
          end
        endcase
      end
      S_WIDX: begin
        st.busWr  = 1'b1;
        st.aSel   = ASEL_IDXREG;
        st.wSel   = WSEL_INDEX;
        nextState = (opc == OP_WR_IDX) ? S_WDAT : S_RDV;
      end
      S_WDAT: begin
        st.busWr  = 1'b1;
        st.aSel   = (opc == OP_WR_IDX) ? ASEL_DATAREG : ASEL_HDR;
        st.wSel   = WSEL_OPA;
        nextState = S_HDR0;
      end
      S_RDV: begin
        st.busRd  = 1'b1;
        st.ldRd   = 1'b1;
        st.aSel   = (opc == OP_RMW_IDX) ? ASEL_DATAREG : ASEL_HDR;
        nextState = S_WBK;
      end
      S_WBK: begin
        st.busWr  = 1'b1;
        st.aSel   = (opc == OP_RMW_IDX) ? ASEL_DATAREG : ASEL_HDR;
        st.wSel   = WSEL_RMW;
        nextState = S_HDR0;
      end
      S_DELAY: begin
        st.tick = 1'b1;
        if (delayLast) nextState = S_HDR0;
      end
      S_POLL: begin
        st.busRd = 1'b1;
        st.aSel  = ASEL_POLL;
        if (pollOk) nextState = S_HDR0;
        else begin
          st.decCount = 1'b1;
          if (remLast) begin
            setTo     = 1'b1;
            nextState = S_HDR0;
          end
        end
      end
      S_FIN:   nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      timeout <= 1'b0;
      error   <= 1'b0;
    end else begin
      state <= nextState;
      if (accept) begin
        timeout <= 1'b0;
        error   <= 1'b0;
      end else begin
        if (setTo)  timeout <= 1'b1;
        if (setErr) error   <= 1'b1;
      end
    end
  end

  assign busy = (state != S_IDLE) && (state != S_FIN);
  assign done = (state == S_FIN);

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_zero_table_R1: assert property (@(posedge clk) disable iff (!rstN)
    (accept && tableAddr == '0) |=> done);

  assert_terminator_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DECODE && hdr == 16'd0) |=> done);

  assert_error_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (error && !accept) |=> error);

  assert_timeout_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (timeout && !accept) |=> timeout);

endmodule

// File: rtl/reg_init_seq.sv
module reg_init_seq
  import reg_init_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W = 13,
  parameter int DATA_W = 32,
  parameter int CYC_PER_US = 100,
  parameter int CHANNELS = 2,
  parameter int BUSY_BIT = 16,
  parameter logic [IDX_W-1:0] IDX_REG_ADDR = 13'h0000,
  parameter logic [IDX_W-1:0] DATA_REG_ADDR = 13'h0004,
  parameter logic [IDX_W-1:0] CLKPM_ADDR = 13'h0012,
  parameter logic [IDX_W-1:0] MEM_STAT_ADDR = 13'h0150
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] tableAddr,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              error,
  output logic [ADDR_W-1:0] romAddr,
  input  logic [7:0]        romData,
  output logic [IDX_W-1:0]  regAddr,
  output logic              regWrite,
  output logic              regRead,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata
);

  strobe_t    st;
  logic [15:0] hdr;
  logic [2:0]  byteIdx;
  logic        countZero, remLast, delayLast, pollOk;

  reg_init_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .tableAddr(tableAddr),
    .hdr(hdr), .byteIdx(byteIdx), .countZero(countZero), .remLast(remLast),
    .delayLast(delayLast), .pollOk(pollOk), .st(st), .busy(busy),
    .done(done), .timeout(timeout), .error(error)
  );

  reg_init_seq_dpath #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .CYC_PER_US(CYC_PER_US),
    .CHANNELS(CHANNELS), .BUSY_BIT(BUSY_BIT), .IDX_REG_ADDR(IDX_REG_ADDR),
    .DATA_REG_ADDR(DATA_REG_ADDR), .CLKPM_ADDR(CLKPM_ADDR),
    .MEM_STAT_ADDR(MEM_STAT_ADDR)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .tableAddr(tableAddr), .romData(romData),
    .regRdata(regRdata), .romAddr(romAddr), .regAddr(regAddr),
    .regWdata(regWdata), .regWrite(regWrite), .regRead(regRead), .hdr(hdr),
    .byteIdx(byteIdx), .countZero(countZero), .remLast(remLast),
    .delayLast(delayLast), .pollOk(pollOk)
  );

  assert_rw_excl_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrite && regRead));

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(regWrite || regRead));

endmodule

// File: tb/reg_init_seq_bench.sv
`timescale 1ns/1ps
module reg_init_seq_bench;

  localparam int CYC = 3;
  localparam logic [12:0] A_IDX  = 13'h1000;
  localparam logic [12:0] A_DATA = 13'h1004;
  localparam logic [12:0] A_CLK  = 13'h1010;
  localparam logic [12:0] A_MEM  = 13'h1014;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [15:0] tableAddr = '0;
  logic busy, done, timeout, error;
  logic [15:0] romAddr;
  logic [7:0]  romData;
  logic [12:0] regAddr;
  logic regWrite, regRead;
  logic [31:0] regWdata, regRdata;

  always #10 clk = ~clk;

  reg_init_seq #(
    .CYC_PER_US(CYC), .CHANNELS(4), .BUSY_BIT(16), .IDX_REG_ADDR(A_IDX),
    .DATA_REG_ADDR(A_DATA), .CLKPM_ADDR(A_CLK), .MEM_STAT_ADDR(A_MEM)
  ) u_reg_init_seq (
    .clk(clk), .rstN(rstN), .start(start), .tableAddr(tableAddr),
    .busy(busy), .done(done), .timeout(timeout), .error(error),
    .romAddr(romAddr), .romData(romData), .regAddr(regAddr),
    .regWrite(regWrite), .regRead(regRead), .regWdata(regWdata),
    .regRdata(regRdata)
  );

  // ROM and register models
  logic [7:0]  rom [0:1023];
  logic [31:0] dirRegs [0:63];
  logic [31:0] idxRegs [0:63];
  logic [12:0] idxPtr = '0;
  int wrCount = 0, rdCount = 0, clkReads = 0, memReads = 0;
  int clkBase = 0, busyReads = 0;
  logic [31:0] memStat = '0;

  assign romData = rom[romAddr[9:0]];

  always @* begin
    if (regAddr == A_DATA)     regRdata = idxRegs[idxPtr[5:0]];
    else if (regAddr == A_CLK) regRdata = ((clkReads - clkBase) < busyReads) ? 32'h0001_0000 : 32'h0;
    else if (regAddr == A_MEM) regRdata = memStat;
    else                       regRdata = dirRegs[regAddr[5:0]];
  end

  always @(posedge clk) begin
    if (regWrite) begin
      wrCount <= wrCount + 1;
      if (regAddr == A_IDX)       idxPtr <= regWdata[12:0];
      else if (regAddr == A_DATA) idxRegs[idxPtr[5:0]] <= regWdata;
      else                        dirRegs[regAddr[5:0]] <= regWdata;
    end
    if (regRead) begin
      rdCount <= rdCount + 1;
      if (regAddr == A_CLK) clkReads <= clkReads + 1;
      if (regAddr == A_MEM) memReads <= memReads + 1;
    end
  end

  int checks = 0, errors = 0;
  int wp = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic b8(input logic [7:0] v);
    rom[wp] = v;
    wp++;
  endtask
  task automatic w16(input logic [15:0] v);
    b8(v[7:0]); b8(v[15:8]);
  endtask
  task automatic w32(input logic [31:0] v);
    w16(v[15:0]); w16(v[31:16]);
  endtask
  task automatic ent(input logic [2:0] op, input logic [12:0] idx);
    w16({op, idx});
  endtask

  task automatic runTable(input int addr, output int cyc);
    @(negedge clk);
    tableAddr = addr[15:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 5000) begin
      errors++;
      $display("FAIL run did not finish at table 0x%0h", addr);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc, base0, w0, r0;
    logic [31:0] seed, v, a, o, v2;
    for (int i = 0; i < 1024; i++) rom[i] = 8'h00;

    repeat (3) @(negedge clk);
    chk("R13 reset busy", {31'b0, busy}, 32'd0);
    chk("R13 reset done", {31'b0, done}, 32'd0);
    chk("R10 reset timeout", {31'b0, timeout}, 32'd0);
    chk("R11 reset error", {31'b0, error}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: zero table address
    w0 = wrCount; r0 = rdCount;
    runTable(0, cyc);
    chk("R1 done next cycle", cyc, 1);
    chk("R1 no bus access", (wrCount - w0) + (rdCount - r0), 0);
    @(negedge clk);
    chk("R13 done one cycle", {31'b0, done}, 32'd0);

    // R3..R6 sweep with arithmetic expectations
    seed = 32'h1234_5678;
    for (int i = 0; i < 8; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345; v  = seed;
      seed = seed * 32'd1103515245 + 32'd12345; a  = seed;
      seed = seed * 32'd1103515245 + 32'd12345; o  = seed;
      seed = seed * 32'd1103515245 + 32'd12345; v2 = seed;
      wp = 16;
      ent(3'b001, 13'(10 + i)); w32(v);
      ent(3'b000, 13'(20 + i)); w32(v2);
      w16(16'h0000);
      w0 = wrCount;
      runTable(16, cyc);
      chk("R4 direct write", dirRegs[10 + i], v);
      chk("R3 indexed write", idxRegs[20 + i], v2);
      chk("R2 write count after terminator", wrCount - w0, 3);
      wp = 64;
      ent(3'b011, 13'(10 + i)); w32(a); w32(o);
      ent(3'b010, 13'(20 + i)); w32(o); w32(a);
      w16(16'h0000);
      r0 = rdCount;
      runTable(64, cyc);
      chk("R6 direct rmw", dirRegs[10 + i], (v & a) | o);
      chk("R5 indexed rmw", idxRegs[20 + i], (v2 & o) | a);
      chk("R5 R6 read count", rdCount - r0, 2);
    end

    // R7: delay cycles relative to count 0
    wp = 128; ent(3'b100, 13'd0); w16(16'd0); w16(16'h0000);
    runTable(128, base0);
    for (int n = 1; n <= 6; n++) begin
      wp = 128; ent(3'b100, 13'd0); w16(16'(n)); w16(16'h0000);
      runTable(128, cyc);
      chk("R7 delay length", cyc - base0, n * CYC);
    end

    // R8/R10: busy-bit poll sweep
    for (int k = 0; k < 5; k++) begin
      for (int c = 0; c < 5; c++) begin
        wp = 160; ent(3'b101, 13'h0003); w16(16'(c)); w16(16'h0000);
        busyReads = k;
        clkBase = clkReads;
        runTable(160, cyc);
        chk("R8 busy poll reads", clkReads - clkBase, (c == 0) ? 0 : ((k < c) ? k + 1 : c));
        chk("R10 busy poll timeout", {31'b0, timeout}, (k >= c) ? 32'd1 : 32'd0);
      end
    end
    busyReads = 0;

    // R9: power-up mask sweep (four channels, mask 0x0F)
    for (int s = 0; s < 16; s++) begin
      wp = 192; ent(3'b101, 13'h0008); w16(16'd3); w16(16'h0000);
      memStat = 32'(s) | 32'hF0;
      r0 = memReads;
      runTable(192, cyc);
      chk("R9 mem poll reads", memReads - r0, (s == 15) ? 1 : 3);
      chk("R9 mem poll timeout", {31'b0, timeout}, (s == 15) ? 32'd0 : 32'd1);
    end

    // R10: walk continues after timeout
    memStat = 32'h0;
    wp = 224; ent(3'b101, 13'h0008); w16(16'd2); ent(3'b001, 13'd40); w32(32'hCAFE_0040); w16(16'h0000);
    runTable(224, cyc);
    chk("R10 continues after timeout", dirRegs[40], 32'hCAFE_0040);
    chk("R10 timeout set", {31'b0, timeout}, 32'd1);
    @(negedge clk);
    chk("R10 timeout sticky", {31'b0, timeout}, 32'd1);

    // R12: unknown sub-command
    wp = 256; ent(3'b101, 13'h0005); w16(16'd7); ent(3'b001, 13'd41); w32(32'h0000_0041); w16(16'h0000);
    r0 = rdCount;
    runTable(256, cyc);
    chk("R12 no reads", rdCount - r0, 0);
    chk("R12 following write", dirRegs[41], 32'h0000_0041);
    chk("R10 timeout cleared by start", {31'b0, timeout}, 32'd0);

    // R11: undefined opcodes
    for (int op = 6; op < 8; op++) begin
      wp = 288; ent(3'b001, 13'd42); w32(32'h1111_0000);
      ent(3'(op), 13'd5); ent(3'b001, 13'd42); w32(32'h2222_0000); w16(16'h0000);
      w0 = wrCount;
      runTable(288, cyc);
      chk("R11 error set", {31'b0, error}, 32'd1);
      chk("R11 later entries skipped", dirRegs[42], 32'h1111_0000);
      chk("R11 write count", wrCount - w0, 1);
    end
    wp = 320; w16(16'h0000);
    runTable(320, cyc);
    chk("R11 error cleared by start", {31'b0, error}, 32'd0);

    // R13: start ignored while busy
    wp = 352; ent(3'b001, 13'd43); w32(32'h0000_0011); w16(16'h0000);
    runTable(352, cyc);
    wp = 384; ent(3'b001, 13'd43); w32(32'h0000_0055); w16(16'h0000);
    wp = 416; ent(3'b100, 13'd0); w16(16'd20); w16(16'h0000);
    @(negedge clk);
    tableAddr = 16'd416; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    tableAddr = 16'd384; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
    chk("R13 walk finished", {31'b0, done}, 32'd1);
    @(negedge clk);
    chk("R13 done pulse width", {31'b0, done}, 32'd0);
    repeat (30) @(negedge clk);
    chk("R13 no second walk", {31'b0, busy}, 32'd0);
    chk("R13 second table untouched", dirRegs[43], 32'h0000_0011);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule